// File: doc/BRIEF.md
# Dual-Port Memory with Mailbox Interrupt Flags

This block is a synchronous dual-port word store with a mailbox interrupt for each side. Each port, left and right, has its own address, enable, write select, output enable, write data, read data and an input that carries the contention-busy indication from the arbitration logic. The two highest addresses of the store double as mailbox slots. The top address, 2^ADDR_W-1, is the inbox of the right port. The address below it, 2^ADDR_W-2, is the inbox of the left port.

To post a message, a port writes into the inbox of the opposite port. That write raises the receiving port's interrupt, which is active low. The receiving port acknowledges by reading its own inbox with output enable asserted, and that read drops the interrupt. The mailbox slots are ordinary memory words, so the posted word can be read back. With ADDR_W=13 the store holds 8K words of 9 bits, and the slots sit at 0x1FFF (right inbox) and 0x1FFE (left inbox). The default ADDR_W is smaller so that the array stays small when elaborated.

Top module: `dp_mbox_irq`

## Requirements
- R1: After reset both interrupt outputs `l_irq_n` and `r_irq_n` are 1 and both read-data outputs are 0.
- R2: A left write (`l_en`=1, `l_we`=1) to address 2^ADDR_W-1 drives `r_irq_n` to 0 after that clock edge.
- R3: A right read (`r_en`=1, `r_we`=0) of address 2^ADDR_W-1 with `r_oe`=1 drives `r_irq_n` to 1 after that edge.
- R4: A right write to address 2^ADDR_W-2 drives `l_irq_n` to 0 after that edge.
- R5: A left read of address 2^ADDR_W-2 with `l_oe`=1 drives `l_irq_n` to 1 after that edge.
- R6: While the acting port's busy input is 1, its write sets no flag and its read clears no flag. The flag keeps its value.
- R7: A flag changes only through the exact access named in R2 to R5. No set happens unless enable and write select are both 1. No clear happens when output enable is 0 or when the wrong port reads the slot.
- R8: If a set and a clear of the same flag happen on the same edge, the flag ends up set (interrupt output 0).
- R9: A read with enable=1, write select=0 and output enable=1 presents the addressed 9-bit word on that port's read data one edge later. This includes the mailbox slots and words written by the other port.
- R10: A write with the writing port's busy input at 1 leaves the memory word unchanged.
- R11: When one port writes an address on the same edge that the other port reads it, the read returns the word held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_en | input | 1 | Left access enable |
| l_we | input | 1 | Left write select (1 write, 0 read) |
| l_oe | input | 1 | Left output enable |
| l_busy | input | 1 | Left contention busy |
| l_addr | input | ADDR_W | Left address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data |
| l_irq_n | output | 1 | Left mailbox interrupt, active low |
| r_en | input | 1 | Right access enable |
| r_we | input | 1 | Right write select |
| r_oe | input | 1 | Right output enable |
| r_busy | input | 1 | Right contention busy |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data |
| r_irq_n | output | 1 | Right mailbox interrupt, active low |

## Verification
The flag assertions assume two things about the inputs. First, busy is a level input that is valid at each edge. Second, the two ports never both write the same word while neither is busy, because the arbitration in front of the block resolves that case. The stimulus drives every input half a cycle away from the active edge. It never issues concurrent writes to one address, so every expected word follows from a per-address formula and from the single-writer history.

// File: rtl/dp_mbox_pkg.sv
package dp_mbox_pkg;

  typedef enum logic {
    SIDE_L = 1'b0,
    SIDE_R = 1'b1
  } side_e;

  // Inbox slot owned by a side: right inbox at the top word, left one below it.
  function automatic int unsigned inbox_slot(int unsigned aw, side_e owner);
    int unsigned top;
    top = (32'd1 << aw) - 32'd1;
    return (owner == SIDE_R) ? top : top - 32'd1;
  endfunction

  function automatic side_e peer_of(side_e s);
    return (s == SIDE_L) ? SIDE_R : SIDE_L;
  endfunction

endpackage

// File: rtl/dp_mbox_decode.sv
module dp_mbox_decode
  import dp_mbox_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter side_e       SIDE   = SIDE_L
) (
  input  logic              en,
  input  logic              we,
  input  logic              oe,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_ok,
  output logic              rd_ok,
  output logic              post,
  output logic              take
);
  localparam logic [ADDR_W-1:0] OWN_SLOT  = ADDR_W'(inbox_slot(ADDR_W, SIDE));
  localparam logic [ADDR_W-1:0] PEER_SLOT = ADDR_W'(inbox_slot(ADDR_W, peer_of(SIDE)));

  always_comb begin
    wr_ok = en && we && !busy;
    rd_ok = en && !we && oe;
    post  = wr_ok && (addr == PEER_SLOT);
    take  = rd_ok && !busy && (addr == OWN_SLOT);
  end
endmodule

// File: rtl/dp_mbox_flag.sv
module dp_mbox_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  output logic irq_n
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= 1'b0;
    else if (set_ev) pend_q <= 1'b1;
    else if (clr_ev) pend_q <= 1'b0;
  end

  assign irq_n = !pend_q;

  a_r2_set_asserts: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> !irq_n);
  a_r3_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ev && !set_ev) |=> irq_n);
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ev && clr_ev) |=> !irq_n);
  a_r6_hold_no_event: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_ev && !clr_ev) |=> $stable(irq_n));
endmodule

// File: rtl/dp_mbox_store.sv
module dp_mbox_store #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_wr,
  input  logic              a_rd,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_wr,
  input  logic              b_rd,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Port b is written first so port a takes an unarbitrated collision.
  always_ff @(posedge clk) begin
    if (b_wr) mem[b_addr] <= b_wdata;
    if (a_wr) mem[a_addr] <= a_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rdata <= '0;
      b_rdata <= '0;
    end else begin
      if (a_rd) a_rdata <= mem[a_addr];
      if (b_rd) b_rdata <= mem[b_addr];
    end
  end

  a_r9_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
    !a_rd |=> $stable(a_rdata));
endmodule

// File: rtl/dp_mbox_irq.sv
module dp_mbox_irq
  import dp_mbox_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_en,
  input  logic              l_we,
  input  logic              l_oe,
  input  logic              l_busy,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_irq_n,
  input  logic              r_en,
  input  logic              r_we,
  input  logic              r_oe,
  input  logic              r_busy,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_irq_n
);
  localparam int unsigned NPORT = 2;

  logic              en_v   [NPORT];
  logic              we_v   [NPORT];
  logic              oe_v   [NPORT];
  logic              busy_v [NPORT];
  logic [ADDR_W-1:0] addr_v [NPORT];
  logic              wr_ok  [NPORT];
  logic              rd_ok  [NPORT];
  logic              post   [NPORT];
  logic              take   [NPORT];
  logic              irq_v  [NPORT];

  assign en_v[0]   = l_en;   assign en_v[1]   = r_en;
  assign we_v[0]   = l_we;   assign we_v[1]   = r_we;
  assign oe_v[0]   = l_oe;   assign oe_v[1]   = r_oe;
  assign busy_v[0] = l_busy; assign busy_v[1] = r_busy;
  assign addr_v[0] = l_addr; assign addr_v[1] = r_addr;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dp_mbox_decode #(.ADDR_W(ADDR_W), .SIDE(side_e'(p))) u_dec (
      .en(en_v[p]), .we(we_v[p]), .oe(oe_v[p]), .busy(busy_v[p]),
      .addr(addr_v[p]), .wr_ok(wr_ok[p]), .rd_ok(rd_ok[p]),
      .post(post[p]), .take(take[p])
    );
    // Flag p is raised by the peer's post and dropped by this port's take.
    dp_mbox_flag u_flag (
      .clk(clk), .rst_n(rst_n),
      .set_ev(post[NPORT-1-p]), .clr_ev(take[p]),
      .irq_n(irq_v[p])
    );
  end

  assign l_irq_n = irq_v[0];
  assign r_irq_n = irq_v[1];

  dp_mbox_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_wr(wr_ok[0]), .a_rd(rd_ok[0]), .a_addr(l_addr), .a_wdata(l_wdata), .a_rdata(l_rdata),
    .b_wr(wr_ok[1]), .b_rd(rd_ok[1]), .b_addr(r_addr), .b_wdata(r_wdata), .b_rdata(r_rdata)
  );

  a_r6_left_busy_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (l_busy && !(r_en && !r_we && r_oe && !r_busy)) |=> $stable(r_irq_n));
  a_r7_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_en && !r_en) |=> ($stable(l_irq_n) && $stable(r_irq_n)));
endmodule

// File: tb/dp_mbox_irq_tb.sv
module dp_mbox_irq_tb;
  localparam int AW = 4;
  localparam int DW = 9;
  localparam int TOP = (1 << AW) - 1;
  localparam int LBOX = TOP - 1;

  logic clk = 0, rst_n = 0;
  logic l_en = 0, l_we = 0, l_oe = 0, l_busy = 0;
  logic r_en = 0, r_we = 0, r_oe = 0, r_busy = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_irq_n, r_irq_n;
  int total = 0, bad = 0;
  logic [DW-1:0] shadow [1 << AW];

  always #4 clk = ~clk;

  dp_mbox_irq #(.ADDR_W(AW), .DATA_W(DW)) u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    l_en = 0; l_we = 0; l_oe = 0; l_busy = 0;
    r_en = 0; r_we = 0; r_oe = 0; r_busy = 0;
  endtask

  function automatic logic [DW-1:0] pat_l(int a); return DW'((a * 37 + 5) & 9'h1FF); endfunction
  function automatic logic [DW-1:0] pat_r(int a); return DW'((a * 91 + 300) & 9'h1FF); endfunction

  task automatic lw(int a, logic [DW-1:0] d);
    idle(); l_en = 1; l_we = 1; l_addr = AW'(a); l_wdata = d; step(); idle();
  endtask
  task automatic rw(int a, logic [DW-1:0] d);
    idle(); r_en = 1; r_we = 1; r_addr = AW'(a); r_wdata = d; step(); idle();
  endtask
  task automatic lr(int a);
    idle(); l_en = 1; l_oe = 1; l_addr = AW'(a); step(); idle();
  endtask
  task automatic rr(int a);
    idle(); r_en = 1; r_oe = 1; r_addr = AW'(a); step(); idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(); step();
    chk("R1 l_irq_n", int'(l_irq_n), 1);
    chk("R1 r_irq_n", int'(r_irq_n), 1);
    chk("R1 l_rdata", int'(l_rdata), 0);
    chk("R1 r_rdata", int'(r_rdata), 0);
    rst_n = 1; step();

    // R9 sweep: left writes every word, right reads all back (R2/R3 at TOP)
    for (int a = 0; a <= TOP; a++) begin lw(a, pat_l(a)); shadow[a] = pat_l(a); end
    chk("R2 r_irq_n after left post", int'(r_irq_n), 0);
    chk("R7 l_irq_n untouched by left post", int'(l_irq_n), 1);
    for (int a = 0; a < TOP; a++) begin rr(a); chk("R9 right readback", int'(r_rdata), int'(shadow[a])); end
    chk("R7 right read of other words keeps flag", int'(r_irq_n), 0);
    rr(TOP);
    chk("R9 right reads mailbox word", int'(r_rdata), int'(shadow[TOP]));
    chk("R3 r_irq_n after right take", int'(r_irq_n), 1);

    // right writes sweep, left reads (R4/R5)
    for (int a = 0; a <= TOP; a++) if (a != TOP) begin rw(a, pat_r(a)); shadow[a] = pat_r(a); end
    chk("R4 l_irq_n after right post", int'(l_irq_n), 0);
    chk("R7 r_irq_n untouched by right post", int'(r_irq_n), 1);
    for (int a = 0; a <= TOP; a++) begin
      lr(a); chk("R9 left readback", int'(l_rdata), int'(shadow[a]));
      if (a == LBOX) chk("R5 l_irq_n after left take", int'(l_irq_n), 1);
    end

    // R7: enable without write, write without enable, oe low, wrong port
    idle(); l_en = 0; l_we = 1; l_addr = AW'(TOP); step(); idle();
    chk("R7 no set without enable", int'(r_irq_n), 1);
    idle(); l_en = 1; l_we = 0; l_oe = 1; l_addr = AW'(TOP); step(); idle();
    chk("R7 no set on read", int'(r_irq_n), 1);
    lw(TOP, 9'h0AA); shadow[TOP] = 9'h0AA;
    chk("R2 set again", int'(r_irq_n), 0);
    idle(); r_en = 1; r_oe = 0; r_addr = AW'(TOP); step(); idle();
    chk("R7 no clear with oe low", int'(r_irq_n), 0);
    lr(TOP);
    chk("R7 wrong port read keeps flag", int'(r_irq_n), 0);
    chk("R9 left reads right inbox", int'(l_rdata), 9'h0AA);

    // R6: busy on the clearing port
    idle(); r_en = 1; r_oe = 1; r_busy = 1; r_addr = AW'(TOP); step(); idle();
    chk("R6 busy blocks clear", int'(r_irq_n), 0);
    rr(TOP); chk("R3 clear after busy drops", int'(r_irq_n), 1);

    // R6/R10: busy on the posting port
    idle(); l_en = 1; l_we = 1; l_busy = 1; l_addr = AW'(TOP); l_wdata = 9'h155; step(); idle();
    chk("R6 busy blocks set", int'(r_irq_n), 1);
    rr(TOP); chk("R10 busy write leaves word", int'(r_rdata), 9'h0AA);
    idle(); r_en = 1; r_we = 1; r_busy = 1; r_addr = AW'(3); r_wdata = 9'h1C3; step(); idle();
    lr(3); chk("R10 busy right write leaves word", int'(l_rdata), int'(shadow[3]));

    // R8: set and clear same edge
    idle(); l_en = 1; l_we = 1; l_addr = AW'(TOP); l_wdata = 9'h077;
    r_en = 1; r_oe = 1; r_addr = AW'(TOP); step(); idle();
    shadow[TOP] = 9'h077;
    chk("R8 set wins", int'(r_irq_n), 0);
    chk("R11 read sees old mailbox word", int'(r_rdata), 9'h0AA);
    rr(TOP); chk("R3 clear after collision", int'(r_irq_n), 1);
    chk("R9 new mailbox word", int'(r_rdata), 9'h077);

    // R8 on left flag with flag already set
    rw(LBOX, 9'h011);
    idle(); r_en = 1; r_we = 1; r_addr = AW'(LBOX); r_wdata = 9'h012;
    l_en = 1; l_oe = 1; l_addr = AW'(LBOX); step(); idle();
    chk("R8 set wins left", int'(l_irq_n), 0);
    chk("R11 left read old word", int'(l_rdata), 9'h011);
    lr(LBOX); chk("R5 clear left", int'(l_irq_n), 1);

    // R11 on an ordinary word
    idle(); l_en = 1; l_we = 1; l_addr = AW'(5); l_wdata = 9'h1F0;
    r_en = 1; r_oe = 1; r_addr = AW'(5); step(); idle();
    chk("R11 read-before-write", int'(r_rdata), int'(shadow[5]));
    rr(5); chk("R9 written value visible", int'(r_rdata), 9'h1F0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule